// File: doc/BRIEF.md
# Prioritized Level-Sensitive Interrupt Controller

This block gathers level-sensitive interrupt requests from a non-maskable input, a bank of fixed-priority external lines and a bank of peripheral sources whose priorities are set by software. Each cycle it picks the highest-priority source that is currently asserted and not masked. It registers that winner's event code and priority, and it raises a request line to the processor core when the winner outranks the core's mask level and the core's global block bit is clear.

Priorities for the peripheral sources come from three 16-bit priority registers. Each register holds four 4-bit fields, and a single field can govern a whole group of peripheral sources. The core issues an accept query to read the winner's event code. Accepting does not clear anything. A source stays pending for as long as its line is held high, and it leaves the pending set only when the line drops.

Top module: `intc_top`

## Requirements
- R1: A write with `wr_en_i`=1 and `wr_sel_i` equal to 0, 1 or 2 stores `wr_data_i` into that priority register at the clock edge. `wr_sel_i`=3 changes nothing. Field f (0..11) lives in register f/4. Slot f%4 selects bits 15:12, 11:8, 7:4 or 3:0 for slots 0, 1, 2 and 3. Field 7 is reserved and sets no source's priority. All registers reset to zero.
- R2: Peripheral source k (0..15) takes its priority from one field. k0 uses field 0, k1 field 1, k2–k3 field 2, k4–k6 field 3, k7 field 4, k8–k9 field 5, k10–k13 field 6, k14 field 8 and k15 field 11.
- R3: A source whose priority is zero never wins, and `win_valid_o` is never 1 with `win_pri_o`=0.
- R4: The non-maskable input has priority 16, above every programmable level. External line j (0..14) has fixed priority 15−j.
- R5: Event codes are 0x1C0 for the non-maskable input, 0x200+0x20·j for external line j, and 0x400+0x20·k for peripheral k. When there is no winner, the code and priority outputs are zero.
- R6: Source indices run as follows: non-maskable input 0, external line j at 1+j, peripheral k at 16+k. Among equal priorities, the lower index wins.
- R7: `irq_o` is 1 exactly when the registered winner is valid, `block_i` was 0, and the winner's priority is strictly greater than `imask_i`, with `block_i` and `imask_i` sampled at the same edge that registered the winner.
- R8: After an edge where `accept_i`=1 and a winner was registered, `ack_valid_o`=1 and `ack_code_o` holds that winner's code. Otherwise both are zero. Accepting leaves the winner in place.
- R9: A source remains a candidate while its line is high. Once it drops, the next-highest pending source becomes the winner.
- R10: While `rst` is high, all outputs and priority registers are cleared at each edge.
- R11: A priority write takes part in arbitration from the cycle after the write edge, so it shows on the outputs one edge later.
- R12: The winner, priority and `irq_o` outputs reflect the request, mask and block inputs sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_i | input | 1 | Non-maskable request level |
| ext_irq_i | input | 15 | External request levels, line j at bit j |
| per_irq_i | input | 16 | Peripheral request levels, source k at bit k |
| wr_en_i | input | 1 | Priority register write strobe |
| wr_sel_i | input | 2 | Priority register select |
| wr_data_i | input | 16 | Priority register write data |
| imask_i | input | 4 | Core interrupt mask level |
| block_i | input | 1 | Core global block bit |
| accept_i | input | 1 | Accept query from the core |
| irq_o | output | 1 | Interrupt request to the core |
| win_valid_o | output | 1 | A winner is registered |
| win_code_o | output | 12 | Winner event code |
| win_pri_o | output | 5 | Winner priority |
| ack_valid_o | output | 1 | Accept response valid |
| ack_code_o | output | 12 | Event code returned by accept |

## Verification
The assertions take for granted that the request, mask and block inputs are held steady around the clock edge. They also assume `rst` is asserted for at least one edge before any check, so that the `$past` values they compare against come from cycles after reset. The bench drives every input at the falling edge and samples outputs at the next falling edge. Random traffic also writes register select 3 and the reserved field, so that stimulus never leaves the decoded behaviour the properties describe.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int PRI_W      = 5;
  localparam int FIELD_W    = 4;
  localparam int REG_W      = 16;
  localparam int N_PRIO_REG = 3;
  localparam int SLOTS      = REG_W / FIELD_W;
  localparam int CODE_W     = 12;
  localparam int SEL_W      = 2;
  localparam int NMI_PRI    = 16;
  localparam logic [CODE_W-1:0] NMI_CODE  = 12'h1C0;
  localparam logic [CODE_W-1:0] EXT_BASE  = 12'h200;
  localparam logic [CODE_W-1:0] PER_BASE  = 12'h400;
  localparam logic [CODE_W-1:0] CODE_STEP = 12'h020;

  // Field that governs peripheral source k; field 7 is reserved.
  function automatic int per_field(input int k);
    case (k)
      0:              return 0;
      1:              return 1;
      2, 3:           return 2;
      4, 5, 6:        return 3;
      7:              return 4;
      8, 9:           return 5;
      10, 11, 12, 13: return 6;
      14:             return 8;
      15:             return 11;
      default:        return 0;
    endcase
  endfunction

  // Bit offset of the low end of field f in the flattened register vector.
  function automatic int field_lsb(input int f);
    return (f / SLOTS) * REG_W + (SLOTS - 1 - (f % SLOTS)) * FIELD_W;
  endfunction
endpackage

// File: rtl/intc_prio_regs.sv
module intc_prio_regs
  import intc_pkg::*;
#(
  parameter int N_REG = N_PRIO_REG
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [SEL_W-1:0]       wr_sel,
  input  logic [REG_W-1:0]       wr_data,
  output logic [N_REG*REG_W-1:0] regs_o
);
  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (wr_en && (wr_sel == SEL_W'(r)))
        q <= wr_data;
    end
    assign regs_o[r*REG_W +: REG_W] = q;
  end
endmodule

// File: rtl/intc_src_prio.sv
module intc_src_prio
  import intc_pkg::*;
#(
  parameter int N_EXT = 15,
  parameter int N_PER = 16,
  parameter int N_REG = N_PRIO_REG,
  localparam int N_SRC = 1 + N_EXT + N_PER
) (
  input  logic [N_REG*REG_W-1:0] regs_i,
  output logic [N_SRC*PRI_W-1:0] pri_o
);
  assign pri_o[0 +: PRI_W] = PRI_W'(NMI_PRI);

  for (genvar j = 0; j < N_EXT; j++) begin : g_ext
    localparam int LVL = (15 - j) > 1 ? (15 - j) : 1;
    assign pri_o[(1+j)*PRI_W +: PRI_W] = PRI_W'(LVL);
  end

  for (genvar k = 0; k < N_PER; k++) begin : g_per
    localparam int FLD = per_field(k);
    localparam int LSB = field_lsb(FLD);
    assign pri_o[(1+N_EXT+k)*PRI_W +: PRI_W] = {1'b0, regs_i[LSB +: FIELD_W]};
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int N_SRC = 32,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]       pend_i,
  input  logic [N_SRC*PRI_W-1:0] pri_i,
  output logic                   valid_o,
  output logic [PRI_W-1:0]       pri_o,
  output logic [IDX_W-1:0]       idx_o
);
  always_comb begin
    valid_o = 1'b0;
    pri_o   = '0;
    idx_o   = '0;
    // Scan from the top index down; ">=" lets lower indices take ties.
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i] && (pri_i[i*PRI_W +: PRI_W] >= pri_o)) begin
        valid_o = 1'b1;
        pri_o   = pri_i[i*PRI_W +: PRI_W];
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int N_EXT = 15,
  parameter int N_PER = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_i,
  input  logic [N_EXT-1:0]  ext_irq_i,
  input  logic [N_PER-1:0]  per_irq_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [3:0]        imask_i,
  input  logic              block_i,
  input  logic              accept_i,
  output logic              irq_o,
  output logic              win_valid_o,
  output logic [CODE_W-1:0] win_code_o,
  output logic [PRI_W-1:0]  win_pri_o,
  output logic              ack_valid_o,
  output logic [CODE_W-1:0] ack_code_o
);
  localparam int N_SRC = 1 + N_EXT + N_PER;
  localparam int IDX_W = $clog2(N_SRC);

  logic [N_PRIO_REG*REG_W-1:0] regs;
  logic [N_SRC*PRI_W-1:0]      pri;
  logic [N_SRC-1:0]            req;
  logic [N_SRC-1:0]            pend;
  logic                        arb_valid;
  logic [PRI_W-1:0]            arb_pri;
  logic [IDX_W-1:0]            arb_idx;
  logic [CODE_W-1:0]           arb_code;

  intc_prio_regs #(.N_REG(N_PRIO_REG)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_sel(wr_sel_i),
    .wr_data(wr_data_i), .regs_o(regs)
  );

  intc_src_prio #(.N_EXT(N_EXT), .N_PER(N_PER), .N_REG(N_PRIO_REG)) u_pri (
    .regs_i(regs), .pri_o(pri)
  );

  assign req = {per_irq_i, ext_irq_i, nmi_i};

  for (genvar i = 0; i < N_SRC; i++) begin : g_pend
    assign pend[i] = req[i] && (pri[i*PRI_W +: PRI_W] != '0);
  end

  intc_arbiter #(.N_SRC(N_SRC)) u_arb (
    .pend_i(pend), .pri_i(pri),
    .valid_o(arb_valid), .pri_o(arb_pri), .idx_o(arb_idx)
  );

  always_comb begin
    if (!arb_valid)
      arb_code = '0;
    else if (arb_idx == '0)
      arb_code = NMI_CODE;
    else if (int'(arb_idx) <= N_EXT)
      arb_code = EXT_BASE + CODE_STEP * CODE_W'(int'(arb_idx) - 1);
    else
      arb_code = PER_BASE + CODE_STEP * CODE_W'(int'(arb_idx) - 1 - N_EXT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid_o <= 1'b0;
      win_code_o  <= '0;
      win_pri_o   <= '0;
      irq_o       <= 1'b0;
      ack_valid_o <= 1'b0;
      ack_code_o  <= '0;
    end else begin
      win_valid_o <= arb_valid;
      win_code_o  <= arb_code;
      win_pri_o   <= arb_pri;
      irq_o       <= arb_valid && !block_i && (arb_pri > {1'b0, imask_i});
      ack_valid_o <= accept_i && win_valid_o;
      ack_code_o  <= (accept_i && win_valid_o) ? win_code_o : '0;
    end
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int N_EXT = 15,
  parameter int N_PER = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              nmi_i,
  input logic [N_EXT-1:0]  ext_irq_i,
  input logic [N_PER-1:0]  per_irq_i,
  input logic [3:0]        imask_i,
  input logic              block_i,
  input logic              accept_i,
  input logic              irq_o,
  input logic              win_valid_o,
  input logic [CODE_W-1:0] win_code_o,
  input logic [PRI_W-1:0]  win_pri_o,
  input logic              ack_valid_o,
  input logic [CODE_W-1:0] ack_code_o
);
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!irq_o && !win_valid_o && !ack_valid_o));

  p_nonzero_win_r3: assert property (@(posedge clk) disable iff (rst)
    win_valid_o |-> (win_pri_o != '0));

  p_nmi_top_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(nmi_i)) |->
      (win_valid_o && win_pri_o == PRI_W'(NMI_PRI) && win_code_o == NMI_CODE));

  p_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(nmi_i) && $past(ext_irq_i) == '0 && $past(per_irq_i) == '0)
      |-> !win_valid_o);

  p_irq_needs_rank_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (win_valid_o && !$past(block_i) && win_pri_o > {1'b0, $past(imask_i)}));

  p_irq_raised_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && win_valid_o && !$past(block_i) && win_pri_o > {1'b0, $past(imask_i)})
      |-> irq_o);

  p_ack_code_r8: assert property (@(posedge clk) disable iff (rst)
    (accept_i && win_valid_o) |=> (ack_valid_o && ack_code_o == $past(win_code_o)));

  p_ack_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !accept_i |=> !ack_valid_o);
endmodule

bind intc_top intc_checker #(.N_EXT(N_EXT), .N_PER(N_PER)) u_chk (.*);

// File: tb/intc_top_bench.sv
module intc_top_bench;
  localparam int NE = 15;
  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        nmi_i;
  logic [NE-1:0] ext_irq_i;
  logic [NP-1:0] per_irq_i;
  logic        wr_en_i;
  logic [1:0]  wr_sel_i;
  logic [15:0] wr_data_i;
  logic [3:0]  imask_i;
  logic        block_i;
  logic        accept_i;
  logic        irq_o, win_valid_o, ack_valid_o;
  logic [11:0] win_code_o, ack_code_o;
  logic [4:0]  win_pri_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] shadow [3];
  logic        prev_valid;
  logic [11:0] prev_code;

  always #4 clk = ~clk;

  intc_top u_intc_top (
    .clk(clk), .rst(rst), .nmi_i(nmi_i), .ext_irq_i(ext_irq_i),
    .per_irq_i(per_irq_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .imask_i(imask_i), .block_i(block_i),
    .accept_i(accept_i), .irq_o(irq_o), .win_valid_o(win_valid_o),
    .win_code_o(win_code_o), .win_pri_o(win_pri_o),
    .ack_valid_o(ack_valid_o), .ack_code_o(ack_code_o)
  );

  // Field mapping of R2, field placement of R1.
  function automatic int fld_of(input int k);
    int t [16] = '{0, 1, 2, 2, 3, 3, 3, 4, 5, 5, 6, 6, 6, 6, 8, 11};
    return t[k];
  endfunction

  function automatic int per_level(input int k);
    int f = fld_of(k);
    return int'((shadow[f/4] >> (12 - 4*(f%4))) & 16'hF);
  endfunction

  // Reference winner: priorities from R2/R4, codes from R5, ties from R6.
  task automatic model(output logic v, output logic [4:0] p, output logic [11:0] c);
    int bp = 0;
    v = 1'b0; p = '0; c = '0;
    if (nmi_i) begin v = 1'b1; bp = 16; c = 12'h1C0; end
    for (int j = 0; j < NE; j++)
      if (ext_irq_i[j] && (15 - j) > bp) begin
        v = 1'b1; bp = 15 - j; c = 12'h200 + 12'(32*j);
      end
    for (int k = 0; k < NP; k++)
      if (per_irq_i[k] && per_level(k) > bp) begin
        v = 1'b1; bp = per_level(k); c = 12'h400 + 12'(32*k);
      end
    p = 5'(bp);
  endtask

  task automatic step(input string tag);
    logic v; logic [4:0] p; logic [11:0] c; logic irq_e, av_e; logic [11:0] ac_e;
    model(v, p, c);
    irq_e = v && !block_i && (p > {1'b0, imask_i});
    av_e  = accept_i && prev_valid;
    ac_e  = av_e ? prev_code : '0;
    if (rst) begin
      v = 0; p = 0; c = 0; irq_e = 0; av_e = 0; ac_e = 0;
    end
    @(posedge clk);
    if (rst) begin
      for (int r = 0; r < 3; r++) shadow[r] = '0;
    end else if (wr_en_i && wr_sel_i != 2'd3) begin
      shadow[wr_sel_i] = wr_data_i;
    end
    prev_valid = v;
    prev_code  = c;
    @(negedge clk);
    checks++;
    if ({win_valid_o, win_code_o, win_pri_o, irq_o, ack_valid_o, ack_code_o} !==
        {v, c, p, irq_e, av_e, ac_e}) begin
      errors++;
      $display("FAIL %s actual v=%0b code=%h pri=%0d irq=%0b ack=%0b/%h expected v=%0b code=%h pri=%0d irq=%0b ack=%0b/%h",
               tag, win_valid_o, win_code_o, win_pri_o, irq_o, ack_valid_o, ack_code_o,
               v, c, p, irq_e, av_e, ac_e);
    end
    wr_en_i = 1'b0;
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [15:0] d, input string tag);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    step(tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7051));
    rst = 1'b1; nmi_i = 0; ext_irq_i = '0; per_irq_i = '0;
    wr_en_i = 0; wr_sel_i = 0; wr_data_i = 0; imask_i = 0; block_i = 0; accept_i = 0;
    prev_valid = 0; prev_code = 0;
    for (int r = 0; r < 3; r++) shadow[r] = '0;
    step("R10 reset");
    step("R10 reset");
    rst = 1'b0;
    step("R10 idle after reset");

    // R3: peripheral with zero priority is masked
    per_irq_i = 16'h0001;
    step("R3 zero priority masks");
    // R1: write register 0 slot 0 -> field 0, peripheral 0 priority 3
    write_reg(2'd0, 16'h3000, "R1 write edge");
    step("R11 new priority in effect");
    step("R1 field 0 sets peripheral 0");
    // R1: select 3 ignored
    write_reg(2'd3, 16'hFFFF, "R1 select 3 write");
    step("R1 select 3 has no effect");
    // R1: reserved field 7 (register 1 bits 3:0)
    per_irq_i = 16'hFFFE;
    write_reg(2'd1, 16'h000F, "R1 reserved field write");
    step("R1 reserved field sets nothing");
    // R2/R6: group field 6 covers 10..13; tie goes to 10
    write_reg(2'd1, 16'h0050, "R2 group field write");
    per_irq_i = 16'h3C00;
    step("R2 group priority");
    step("R6 tie lower index wins");
    // R9: drop source 10, next pending takes over
    per_irq_i = 16'h3800;
    step("R9 next pending after deassert");
    // R8: accept holds winner
    accept_i = 1'b1;
    step("R8 accept");
    step("R8 accept does not retire");
    accept_i = 1'b0;
    // R7: mask compares
    imask_i = 4'd5;
    step("R7 mask equal blocks irq");
    imask_i = 4'd4;
    step("R7 mask below raises irq");
    block_i = 1'b1;
    step("R7 block bit suppresses irq");
    block_i = 1'b0;
    // R4/R5: external and non-maskable
    per_irq_i = '0; ext_irq_i = 15'h0008;
    step("R5 external line 3 code");
    ext_irq_i = 15'h7FFF; nmi_i = 1'b1; imask_i = 4'hF;
    step("R4 non-maskable above all");
    nmi_i = 1'b0;
    step("R4 external line 0 highest fixed");
    // R11: reprioritise a pending source
    ext_irq_i = '0; per_irq_i = 16'h0401;
    write_reg(2'd0, 16'h9000, "R11 raise pending source");
    step("R11 change visible");
    // R10: mid-run reset
    rst = 1'b1;
    step("R10 mid-run reset");
    rst = 1'b0;
    step("R10 registers cleared");

    for (int n = 0; n < 3000; n++) begin
      nmi_i     = ($urandom % 24) == 0;
      ext_irq_i = 15'($urandom & $urandom & $urandom);
      per_irq_i = 16'($urandom & $urandom);
      wr_en_i   = ($urandom % 6) == 0;
      wr_sel_i  = 2'($urandom);
      wr_data_i = 16'($urandom);
      imask_i   = 4'($urandom);
      block_i   = ($urandom % 4) == 0;
      accept_i  = 1'($urandom);
      step("R12 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule